// File: doc/BRIEF.md
# Bus-Mapped Serial Transceiver with Laddered Baud Prescaler

A serial transmitter and receiver for 8-bit frames with no parity and one stop bit, attached to a simple word-wide register bus. Software configures it through a control word and moves bytes through a data word. A write to the data word queues a byte for sending. A read of the data word removes the oldest received byte and reports in the same word whether that byte was valid.

Bit timing is the product of a coarse prescaler and a fine divider. A 3-bit code selects the prescaler from a non-uniform ladder: 2, 4, 8, 64, 128, 1024, 2048 and 4096 system clocks. A 10-bit field holds the number of prescaled periods per bit, minus one. Small first-in first-out queues on both directions report empty, half-full and full levels. Five enables choose which levels drive two separate interrupt outputs. An optional clear-to-send / request-to-send handshake paces the link, and a sticky flag records received bytes that found the queue full.

Top module: `mmio_serial_port`

## Requirements
- R1: After reset the control word reads 0x00000000, the data word reads 0x00000000, `ser_txd_o` is 1, and both interrupt outputs and `rts_no` are 0.
- R2: The control word is at address 0x0 and the data word is at 0x4. In the control word, bit 0 = enable, bit 1 = simulation select (stored only), bit 2 = handshake enable, bits 5:3 = prescaler code, bits 15:6 = divider, bits 26:22 = interrupt enables. All of these read back as written. Bits 29:27 read 0.
- R3: A transmitted frame is a 0 start bit, then data bits least significant first, then a 1 stop bit. Every bit lasts P = R(code) × (divider + 1) clocks. The line idles at 1.
- R4: R(code) for codes 0..7 is 2, 4, 8, 64, 128, 1024, 2048, 4096 (for example code 3 with divider 0 gives 64 clocks per bit, and code 5 with divider 0 gives 1024).
- R5: Control bit 19 = transmit queue not empty, bit 20 = at least half full, bit 21 = full. Bit 31 = transmitter busy, which is 1 while a frame is on the line or a byte is queued.
- R6: Reading the data word while a received byte is queued returns that byte in bits 7:0 and 1 in bit 16, and removes the byte. When the queue is empty the read returns 0.
- R7: A received frame whose stop bit is 0 is discarded and queues nothing.
- R8: Control bit 16 = receive queue not empty, bit 17 = at least half full, bit 18 = full. A byte completed while the receive queue is full is dropped and sets bit 30. Bit 30 stays set until the next write to the control word.
- R9: `irq_rx_o` is a level equal to enable AND ((bit 22 AND receive not empty) OR (bit 23 AND receive half) OR (bit 24 AND receive full)).
- R10: When a frame's stop bit ends, `irq_tx_o` is 1 for exactly one cycle if (bit 25 AND the transmit queue is empty) OR (bit 26 AND the transmit queue is below half). Otherwise it stays 0.
- R11: With handshake enabled, no new frame starts while `cts_ni` is 1. `rts_no` is 1 exactly while handshake is enabled and the receive queue is full.
- R12: While enable is 0, both queues are emptied, the line is held at 1, and data word writes are ignored. A byte written in that state is never sent after enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Byte address: 0x0 control, 0x4 data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| ser_txd_o | output | 1 | Serial transmit line |
| ser_rxd_i | input | 1 | Serial receive line, asynchronous |
| cts_ni | input | 1 | Clear to send, active low |
| rts_no | output | 1 | Request to send, active low (1 = hold off) |
| irq_tx_o | output | 1 | Transmit completion pulse |
| irq_rx_o | output | 1 | Receive level interrupt |

## Verification
The bench checks the transmit line against a per-clock bit model for three prescaler codes. This catches a ladder entry wrong by a factor of two or eight, which would stretch or squeeze every bit and fail the compare within the first bit. Receive is driven with a fifth byte arriving into a full queue and with a frame whose stop bit is low. A design that overwrote the queue, or accepted the framing error, would return wrong bytes on read-out or show bit 16 set. The sticky overrun must survive data reads and clear only on a control write, and a byte written while disabled must never appear on the line after re-enable. Handshake hold and the one-cycle transmit pulse, with and without its enable, complete the set.

// File: rtl/mmio_serial_pkg.sv
package mmio_serial_pkg;
  localparam int DIV_W   = 10;
  localparam int CODE_W  = 3;
  localparam int BYTE_W  = 8;
  localparam int FRAME_N = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // log2 of the coarse ratio for each prescaler code
  function automatic logic [3:0] presc_shift(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    presc_shift = 4'd1;
      3'd1:    presc_shift = 4'd2;
      3'd2:    presc_shift = 4'd3;
      3'd3:    presc_shift = 4'd6;
      3'd4:    presc_shift = 4'd7;
      3'd5:    presc_shift = 4'd10;
      3'd6:    presc_shift = 4'd11;
      default: presc_shift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/mmio_serial_baud.sv
module mmio_serial_baud
  import mmio_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tick_o,
  output logic              mid_o
);
  localparam int CNT_W = DIV_W + 13;

  logic [CNT_W-1:0] cnt_q, cnt_d, period;

  assign period = (CNT_W'(div_i) + CNT_W'(1)) << presc_shift(code_i);
  assign tick_o = run_i && (cnt_q == period - CNT_W'(1));
  assign mid_o  = run_i && (cnt_q == (period >> 1));

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mmio_serial_fifo.sv
module mmio_serial_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         half_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d, count;
  logic         do_push, do_pop;

  assign count   = wptr_q - rptr_q;
  assign full_o  = (count == (AW+1)'(DEPTH));
  assign empty_o = (count == '0);
  assign half_o  = (count >= (AW+1)'(DEPTH / 2));
  assign rdata_o = mem_q[rptr_q[AW-1:0]];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + 1'b1;
      if (do_pop)  rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end

  AST_FIFO_PUSH_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !clr_i) |=> !empty_o); // R5
endmodule

// File: rtl/mmio_serial_tx.sv
module mmio_serial_tx
  import mmio_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  logic                 busy_q, busy_d, tick, mid_unused;
  logic [FRAME_N-1:0]   sh_q, sh_d;
  logic [3:0]           n_q, n_d;

  mmio_serial_baud u_baud (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (busy_q && en_i),
    .code_i(code_i), .div_i (div_i), .tick_o(tick), .mid_o (mid_unused)
  );

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign busy_o = busy_q;
  assign done_o = busy_q && tick && (n_q == 4'(FRAME_N - 1));

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    n_d    = n_q;
    if (!en_i) begin
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data_i, 1'b0};
        n_d    = '0;
      end
    end else if (tick) begin
      if (n_q == 4'(FRAME_N - 1)) begin
        busy_d = 1'b0;
      end else begin
        sh_d = {1'b1, sh_q[FRAME_N-1:1]};
        n_d  = n_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      n_q    <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      n_q    <= n_d;
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && en_i && !busy_q) |=> !txd_o); // R3
endmodule

// File: rtl/mmio_serial_rx.sv
module mmio_serial_rx
  import mmio_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] byte_o
);
  rx_state_e          st_q, st_d;
  logic               rx_m_q, rx_s_q, mid, tick_unused;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [2:0]         n_q, n_d;

  mmio_serial_baud u_baud (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (st_q != RX_IDLE),
    .code_i(code_i), .div_i (div_i), .tick_o(tick_unused), .mid_o (mid)
  );

  assign byte_o = sh_q;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    n_d    = n_q;
    push_o = 1'b0;
    if (!en_i) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE:  if (!rx_s_q) st_d = RX_START;
        RX_START: if (mid) begin
                    st_d = rx_s_q ? RX_IDLE : RX_DATA;
                    n_d  = '0;
                  end
        RX_DATA:  if (mid) begin
                    sh_d = {rx_s_q, sh_q[BYTE_W-1:1]};
                    n_d  = n_q + 3'd1;
                    if (n_q == 3'd7) st_d = RX_STOP;
                  end
        default:  if (mid) begin
                    push_o = rx_s_q;
                    st_d   = RX_IDLE;
                  end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m_q <= 1'b1;
      rx_s_q <= 1'b1;
      st_q   <= RX_IDLE;
      sh_q   <= '0;
      n_q    <= '0;
    end else begin
      rx_m_q <= rxd_i;
      rx_s_q <= rx_m_q;
      st_q   <= st_d;
      sh_q   <= sh_d;
      n_q    <= n_d;
    end
  end

  AST_RX_NO_PUSH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !push_o); // R12
endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
  import mmio_serial_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        ser_txd_o,
  input  logic        ser_rxd_i,
  input  logic        cts_ni,
  output logic        rts_no,
  output logic        irq_tx_o,
  output logic        irq_rx_o
);
  logic [1:0]        rs_q;
  logic              rst_n;
  logic              en_q, en_d, sim_q, sim_d, fc_q, fc_d, ovr_q, ovr_d;
  logic              irq_tx_q, irq_tx_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [4:0]        ien_q, ien_d;
  logic [1:0]        cts_q;
  logic              ctrl_wr, data_wr, data_rd, unused_wdata;
  logic              tx_empty, tx_half, tx_full, tx_busy, tx_done, tx_load;
  logic              rx_empty, rx_half, rx_full, rx_push;
  logic [BYTE_W-1:0] tx_byte, rx_byte, rx_head;
  logic [31:0]       ctrl_word, data_word;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  assign ctrl_wr      = bus_sel_i && bus_we_i && (bus_addr_i == 3'h0);
  assign data_wr      = bus_sel_i && bus_we_i && (bus_addr_i == 3'h4) && en_q;
  assign data_rd      = bus_sel_i && !bus_we_i && (bus_addr_i == 3'h4);
  assign unused_wdata = ^{bus_wdata_i[31:27], bus_wdata_i[21:16]};
  assign tx_load      = en_q && !tx_busy && !tx_empty && !(fc_q && cts_q[1]);

  mmio_serial_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(!en_q), .push_i(data_wr),
    .wdata_i(bus_wdata_i[BYTE_W-1:0]), .pop_i(tx_load), .rdata_o(tx_byte),
    .empty_o(tx_empty), .half_o(tx_half), .full_o(tx_full)
  );

  mmio_serial_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(!en_q), .push_i(rx_push),
    .wdata_i(rx_byte), .pop_i(data_rd), .rdata_o(rx_head),
    .empty_o(rx_empty), .half_o(rx_half), .full_o(rx_full)
  );

  mmio_serial_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_q), .load_i(tx_load),
    .data_i(tx_byte), .code_i(code_q), .div_i(div_q),
    .txd_o(ser_txd_o), .busy_o(tx_busy), .done_o(tx_done)
  );

  mmio_serial_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_q), .rxd_i(ser_rxd_i),
    .code_i(code_q), .div_i(div_q), .push_o(rx_push), .byte_o(rx_byte)
  );

  assign ctrl_word = {tx_busy || !tx_empty, ovr_q, 3'b000, ien_q,
                      tx_full, tx_half, !tx_empty, rx_full, rx_half, !rx_empty,
                      div_q, code_q, fc_q, sim_q, en_q};
  assign data_word = rx_empty ? 32'h0 : {15'h0, 1'b1, 8'h0, rx_head};

  always_comb begin
    case (bus_addr_i)
      3'h0:    bus_rdata_o = ctrl_word;
      3'h4:    bus_rdata_o = data_word;
      default: bus_rdata_o = 32'h0;
    endcase
  end

  assign rts_no   = fc_q && rx_full;
  assign irq_rx_o = en_q && ((ien_q[0] && !rx_empty) || (ien_q[1] && rx_half) ||
                             (ien_q[2] && rx_full));
  assign irq_tx_o = irq_tx_q;

  always_comb begin
    en_d   = en_q;
    sim_d  = sim_q;
    fc_d   = fc_q;
    code_d = code_q;
    div_d  = div_q;
    ien_d  = ien_q;
    if (ctrl_wr) begin
      en_d   = bus_wdata_i[0];
      sim_d  = bus_wdata_i[1];
      fc_d   = bus_wdata_i[2];
      code_d = bus_wdata_i[5:3];
      div_d  = bus_wdata_i[15:6];
      ien_d  = bus_wdata_i[26:22];
    end
    ovr_d    = ctrl_wr ? 1'b0 : (ovr_q || (rx_push && rx_full));
    irq_tx_d = tx_done && ((ien_q[3] && tx_empty) || (ien_q[4] && !tx_half));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sim_q    <= 1'b0;
      fc_q     <= 1'b0;
      code_q   <= '0;
      div_q    <= '0;
      ien_q    <= '0;
      ovr_q    <= 1'b0;
      irq_tx_q <= 1'b0;
      cts_q    <= 2'b11;
    end else begin
      en_q     <= en_d;
      sim_q    <= sim_d;
      fc_q     <= fc_d;
      code_q   <= code_d;
      div_q    <= div_d;
      ien_q    <= ien_d;
      ovr_q    <= ovr_d;
      irq_tx_q <= irq_tx_d;
      cts_q    <= {cts_q[0], cts_ni};
    end
  end

  AST_OVERRUN_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_push && rx_full && !ctrl_wr) |=> ovr_q); // R8
  AST_CTS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fc_q && cts_q[1] && !tx_busy) |=> !tx_busy); // R11
  AST_TX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_tx_o |=> !irq_tx_o); // R10
  AST_OFF_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_q |=> ser_txd_o); // R12
endmodule

// File: tb/mmio_serial_port_tb.sv
module mmio_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        txd, rxd = 1'b1, cts_n = 1'b0, rts_n, irq_tx, irq_rx;

  int n_chk = 0, n_err = 0;
  int bit_p = 16;
  logic [7:0] txq[$];
  string frame_req = "R3";
  bit in_fr = 1'b0, fr_bad, fr_noexp;
  int k, frames_seen = 0, irq_tx_cnt = 0;
  logic [7:0] exp_b;

  always #5 clk = ~clk;

  mmio_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ser_txd_o(txd), .ser_rxd_i(rxd), .cts_ni(cts_n), .rts_no(rts_n),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(input int code, input int dv, input int fc, input int ien);
    return 32'h1 | (32'(fc) << 2) | (32'(code) << 3) | (32'(dv) << 6) | (32'(ien) << 22);
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0; addr = 3'h0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); sel = 0; addr = 3'h0;
  endtask

  task automatic send_tx(input logic [7:0] b);
    txq.push_back(b);
    bus_wr(3'h4, {24'h0, b});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int guard;
    guard = 0;
    do begin bus_rd(3'h0, v); guard++; end while (v[31] && guard < 20000);
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rxd = 0; repeat (bit_p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bit_p) @(negedge clk); end
    rxd = stop; repeat (bit_p) @(negedge clk);
    rxd = 1; repeat (2 * bit_p) @(negedge clk);
  endtask

  // per-clock reference for the transmit line
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_tx) irq_tx_cnt++;
      if (!in_fr && txd === 1'b0) begin
        in_fr = 1; k = 0; fr_bad = 0; fr_noexp = (txq.size() == 0);
        exp_b = fr_noexp ? 8'h00 : txq.pop_front();
      end
      if (in_fr) begin
        int bn;
        logic ev;
        bn = k / bit_p;
        ev = (bn == 0) ? 1'b0 : (bn == 9) ? 1'b1 : exp_b[bn-1];
        if (txd !== ev) fr_bad = 1;
        k++;
        if (k == 10 * bit_p) begin
          in_fr = 0; frames_seen++;
          chk(!fr_bad && !fr_noexp, {frame_req, " tx frame bits"}, {31'h0, fr_bad}, {24'h0, exp_b});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(3'h0, v); chk(v == 32'h0, "R1 ctrl after reset", v, 32'h0);
    bus_rd(3'h4, v); chk(v == 32'h0, "R1 data after reset", v, 32'h0);
    chk(txd && !irq_tx && !irq_rx && !rts_n, "R1 pins after reset",
        {28'h0, txd, irq_tx, irq_rx, rts_n}, 32'h8);

    // R2 readback of all writable fields
    bus_wr(3'h0, 32'hFFFF_FFFF);
    bus_rd(3'h0, v); chk(v == 32'h07C0_FFFF, "R2 ctrl readback", v, 32'h07C0_FFFF);

    // R3 single frame, P = 2*8 = 16
    bus_wr(3'h0, cfg(0, 7, 0, 0)); bit_p = 16;
    send_tx(8'hA5); wait_idle();
    chk(frames_seen == 1, "R3 frame count", frames_seen, 1);

    // R5 transmit queue levels
    send_tx(8'h3C); send_tx(8'h81); send_tx(8'hFF);
    bus_rd(3'h0, v);
    chk(v[31] && v[21:19] == 3'b011, "R5 tx two queued", {29'h0, v[21:19]}, 32'h3);
    send_tx(8'h00); send_tx(8'h6E);
    bus_rd(3'h0, v);
    chk(v[31] && v[21:19] == 3'b111, "R5 tx full", {29'h0, v[21:19]}, 32'h7);
    wait_idle();
    bus_rd(3'h0, v);
    chk(!v[31] && v[21:19] == 3'b000, "R5 tx drained", v, 32'h0);
    chk(frames_seen == 6, "R3 burst frame count", frames_seen, 6);

    // R4 ladder: code 3 -> 64, code 5 -> 1024
    frame_req = "R4";
    bus_wr(3'h0, cfg(3, 0, 0, 0)); bit_p = 64;
    send_tx(8'h5A); wait_idle();
    bus_wr(3'h0, cfg(5, 0, 0, 0)); bit_p = 1024;
    send_tx(8'hC3); wait_idle();
    chk(frames_seen == 8, "R4 ladder frames", frames_seen, 8);
    frame_req = "R3";
    bus_wr(3'h0, cfg(0, 7, 0, 0)); bit_p = 16;

    // R10 transmit pulse with and without its enable
    bus_wr(3'h0, cfg(0, 7, 0, 5'b01000));
    i0 = irq_tx_cnt; send_tx(8'h19); wait_idle();
    chk(irq_tx_cnt - i0 == 1, "R10 pulse when enabled", irq_tx_cnt - i0, 1);
    bus_wr(3'h0, cfg(0, 7, 0, 0));
    i0 = irq_tx_cnt; send_tx(8'h91); wait_idle();
    chk(irq_tx_cnt - i0 == 0, "R10 no pulse when disabled", irq_tx_cnt - i0, 0);

    // R6 receive and read-out
    rx_send(8'h47, 1'b1);
    bus_rd(3'h0, v); chk(v[16], "R6 rx not empty", v, 32'h1_0000);
    bus_rd(3'h4, v); chk(v == 32'h0001_0047, "R6 data read", v, 32'h0001_0047);
    bus_rd(3'h4, v); chk(v == 32'h0, "R6 empty read", v, 32'h0);

    // R7 bad stop bit
    rx_send(8'hE1, 1'b0);
    bus_rd(3'h0, v); chk(!v[16], "R7 bad frame dropped", v, 32'h0);
    rx_send(8'h2B, 1'b1);
    bus_rd(3'h4, v); chk(v == 32'h0001_002B, "R7 next frame ok", v, 32'h0001_002B);

    // R8 R9 R11 levels, interrupt, handshake, overrun
    bus_wr(3'h0, cfg(0, 7, 1, 5'b00010));
    rx_send(8'h11, 1'b1);
    chk(!irq_rx, "R9 irq low at one byte", {31'h0, irq_rx}, 0);
    rx_send(8'h22, 1'b1);
    chk(irq_rx, "R9 irq high at half", {31'h0, irq_rx}, 1);
    bus_rd(3'h0, v); chk(v[18:16] == 3'b011, "R8 rx half", {29'h0, v[18:16]}, 3);
    rx_send(8'h33, 1'b1); rx_send(8'h44, 1'b1);
    bus_rd(3'h0, v); chk(v[18:16] == 3'b111 && !v[30], "R8 rx full", v, 32'h7_0000);
    chk(rts_n, "R11 rts high when full", {31'h0, rts_n}, 1);
    rx_send(8'h55, 1'b1);
    bus_rd(3'h0, v); chk(v[30], "R8 overrun set", v, 32'h4000_0000);
    bus_rd(3'h4, v); chk(v == 32'h0001_0011, "R8 order 1", v, 32'h0001_0011);
    bus_rd(3'h4, v); chk(v == 32'h0001_0022, "R8 order 2", v, 32'h0001_0022);
    bus_rd(3'h4, v); chk(v == 32'h0001_0033, "R8 order 3", v, 32'h0001_0033);
    bus_rd(3'h4, v); chk(v == 32'h0001_0044, "R8 order 4", v, 32'h0001_0044);
    bus_rd(3'h4, v); chk(v == 32'h0, "R8 fifth dropped", v, 32'h0);
    chk(!rts_n, "R11 rts low after drain", {31'h0, rts_n}, 0);
    bus_rd(3'h0, v); chk(v[30], "R8 overrun sticky", v, 32'h4000_0000);
    bus_wr(3'h0, cfg(0, 7, 1, 0));
    bus_rd(3'h0, v); chk(!v[30], "R8 overrun cleared", v, 32'h0);

    // R11 clear-to-send hold
    cts_n = 1; repeat (4) @(negedge clk);
    f0 = frames_seen; send_tx(8'h96);
    repeat (40) @(negedge clk);
    bus_rd(3'h0, v);
    chk(v[31] && v[19] && !in_fr && txd, "R11 held by cts", v, 32'h8008_0000);
    cts_n = 0; repeat (12 * bit_p) @(negedge clk);
    chk(frames_seen == f0 + 1, "R11 sent after cts", frames_seen, f0 + 1);

    // R12 disable clears and ignores
    cts_n = 1; repeat (4) @(negedge clk);
    bus_wr(3'h4, 32'h77);
    rx_send(8'h5E, 1'b1);
    bus_wr(3'h0, 32'h0);
    bus_rd(3'h0, v); chk(v == 32'h0, "R12 cleared on disable", v, 32'h0);
    bus_wr(3'h4, 32'h12);
    cts_n = 0;
    f0 = frames_seen;
    bus_wr(3'h0, cfg(0, 7, 0, 0));
    repeat (15 * bit_p) @(negedge clk);
    bus_rd(3'h0, v);
    chk(frames_seen == f0 && v[21:16] == 6'h0 && txd, "R12 nothing sent after enable", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule